// File: doc/BRIEF.md
# Dual-Bus Synchronous SRAM with Streaming

This block is a clocked word store with two separate 9-bit data buses, here called the P bus and the S bus. Each bus carries eight data bits and a parity bit, and each has its own input-enable and output-enable, all active low. A write stores the word from whichever single bus has its input-enable asserted. In the same clock the block can present that word on the opposite bus, so one agent writes the array while another sees the data stream past. Every bidirectional bus appears as a separate input, output and drive-enable, so the bus can be tied to a pad or to a shared on-chip line.

The address and both chip selects are sampled on the falling clock edge. The write strobe, the input-enables and the bus data are sampled on the rising edge, and all bus outputs are updated only then. A read cycle, with the strobe high and the chip selected, presents the addressed word on both buses one rising edge later. An output-enable gates its bus's drive with no clock in between.

Top module: `dual_bus_sram`

## Requirements
- R1: A word is stored only when, at the same rising edge, `wr_n` is 0 and the chip-select values captured at the preceding falling edge were `chip_en_n`=0 and `chip_en`=1.
- R2: In a qualified write, the stored word is `p_in` when only `p_in_en_n` is 0, and `s_in` when only `s_in_en_n` is 0.
- R3: In a qualified write where both input-enables are 0, or both are 1, no location of the array changes.
- R4: All 9 bits of a bus word, including bit 8 (the parity bit), are stored and returned unchanged.
- R5: After a write from the P bus, the S bus carries the written word (`s_out`) with `s_oe`=1 if `s_out_en_n` is 0. After a write from the S bus, the P bus carries the word with `p_oe`=1 if `p_out_en_n` is 0. The source bus does not drive after that edge.
- R6: After a rising edge that ends a write cycle with both input-enables equal, `p_oe` and `s_oe` are both 0.
- R7: While `p_out_en_n` is 1, `p_oe` is 0, and while `s_out_en_n` is 1, `s_oe` is 0. This takes effect in the same cycle, with no clock edge in between.
- R8: While `wr_n` is 0 and a bus is the only one with its input-enable at 0, that bus's drive-enable is 0, even if its output-enable is 0.
- R9: After a selected cycle with `wr_n`=1, both `p_out` and `s_out` carry the word at the captured address. Each drive-enable follows its own output-enable.
- R10: After a deselected cycle, both drive-enables are 0 and the array is unchanged.
- R11: Changes to the address and chip selects after the falling edge have no effect on the operation at the next rising edge.
- R12: While `rst` is 1, and on the first edge after it, both drive-enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Word address, sampled on the falling edge |
| wr_n | input | 1 | Write strobe, active low, sampled on the rising edge |
| chip_en_n | input | 1 | Active-low chip select, sampled on the falling edge |
| chip_en | input | 1 | Active-high chip select, sampled on the falling edge |
| p_in_en_n | input | 1 | P bus input-enable, active low |
| s_in_en_n | input | 1 | S bus input-enable, active low |
| p_out_en_n | input | 1 | P bus output-enable, active low, asynchronous gate |
| s_out_en_n | input | 1 | S bus output-enable, active low, asynchronous gate |
| p_in | input | 9 | Data arriving from the P bus |
| p_out | output | 9 | Data the block drives onto the P bus |
| p_oe | output | 1 | P bus drive-enable |
| s_in | input | 9 | Data arriving from the S bus |
| s_out | output | 9 | Data the block drives onto the S bus |
| s_oe | output | 1 | S bus drive-enable |

## Verification
Assertions check four things on every clock: streaming hand-off, the quiet buses after a no-operation or deselected cycle, output-enable gating, and the rule that the selected source bus never drives. Only the bench's sequences can show what the array holds. It sweeps every address from both buses with values that exercise bit 8. It then reads each word back and checks that writes rejected by an equal input-enable pair or an inactive chip select leave the stored contents intact. It also shows that a late change to the address or chip selects after the falling edge is ignored.

// File: rtl/dbsram_pkg.sv
package dbsram_pkg;

    localparam int WORD_W = 9;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_READ,
        OP_WR_P,
        OP_WR_S,
        OP_NOP
    } op_e;

    typedef struct packed {
        word_t data;
        logic  p_vld;
        logic  s_vld;
    } drv_t;

    function automatic op_e decode_op(input logic sel, input logic wr_n,
                                      input logic p_ie_n, input logic s_ie_n);
        op_e r;
        if (!sel)                    r = OP_IDLE;
        else if (wr_n)               r = OP_READ;
        else if (!p_ie_n && s_ie_n)  r = OP_WR_P;
        else if (p_ie_n && !s_ie_n)  r = OP_WR_S;
        else                         r = OP_NOP;
        return r;
    endfunction

endpackage

// File: rtl/dbsram_ctrl.sv
module dbsram_ctrl
    import dbsram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          chip_en_n,
    input  logic          chip_en,
    input  logic          wr_n,
    input  logic          p_in_en_n,
    input  logic          s_in_en_n,
    output logic [AW-1:0] addr_q,
    output op_e           op,
    output logic          p_is_src,
    output logic          s_is_src
);

    logic cen_n_q;
    logic cen_q;

    // falling-edge capture of address and chip selects
    always_ff @(negedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            cen_n_q <= 1'b1;
            cen_q   <= 1'b0;
        end else begin
            addr_q  <= addr;
            cen_n_q <= chip_en_n;
            cen_q   <= chip_en;
        end
    end

    always_comb begin
        op       = decode_op(!cen_n_q && cen_q, wr_n, p_in_en_n, s_in_en_n);
        p_is_src = !wr_n && !p_in_en_n && s_in_en_n;
        s_is_src = !wr_n && p_in_en_n && !s_in_en_n;
    end

endmodule

// File: rtl/dbsram_array.sv
module dbsram_array
    import dbsram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  word_t         wdata,
    output word_t         rdata
);

    localparam int DEPTH = 1 << AW;

    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/dbsram_busio.sv
module dbsram_busio
    import dbsram_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  op_e   op,
    input  logic  p_is_src,
    input  logic  s_is_src,
    input  word_t p_in,
    input  word_t s_in,
    input  word_t rdata,
    input  logic  p_out_en_n,
    input  logic  s_out_en_n,
    output word_t p_out,
    output word_t s_out,
    output logic  p_oe,
    output logic  s_oe
);

    drv_t drv_q;
    drv_t drv_d;

    always_comb begin
        drv_d = '{data: drv_q.data, p_vld: 1'b0, s_vld: 1'b0};
        unique case (op)
            OP_READ: drv_d = '{data: rdata, p_vld: 1'b1, s_vld: 1'b1};
            OP_WR_P: drv_d = '{data: p_in,  p_vld: 1'b0, s_vld: 1'b1};
            OP_WR_S: drv_d = '{data: s_in,  p_vld: 1'b1, s_vld: 1'b0};
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) drv_q <= '{data: '0, p_vld: 1'b0, s_vld: 1'b0};
        else     drv_q <= drv_d;
    end

    assign p_out = drv_q.data;
    assign s_out = drv_q.data;
    assign p_oe  = drv_q.p_vld && !p_out_en_n && !p_is_src;
    assign s_oe  = drv_q.s_vld && !s_out_en_n && !s_is_src;

    assert_stream_p_to_s_R5: assert property (@(posedge clk) disable iff (rst)
        (op == OP_WR_P) |=> (drv_q.s_vld && !drv_q.p_vld && s_out == $past(p_in)));

    assert_stream_s_to_p_R5: assert property (@(posedge clk) disable iff (rst)
        (op == OP_WR_S) |=> (drv_q.p_vld && !drv_q.s_vld && p_out == $past(s_in)));

    assert_nop_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (op == OP_NOP || op == OP_IDLE) |=> (!p_oe && !s_oe));

    assert_oe_release_R7: assert property (@(posedge clk) disable iff (rst)
        (p_out_en_n |-> !p_oe) and (s_out_en_n |-> !s_oe));

    assert_src_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (p_is_src |-> !p_oe) and (s_is_src |-> !s_oe));

endmodule

// File: rtl/dual_bus_sram.sv
module dual_bus_sram
    import dbsram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          wr_n,
    input  logic          chip_en_n,
    input  logic          chip_en,
    input  logic          p_in_en_n,
    input  logic          s_in_en_n,
    input  logic          p_out_en_n,
    input  logic          s_out_en_n,
    input  logic [8:0]    p_in,
    output logic [8:0]    p_out,
    output logic          p_oe,
    input  logic [8:0]    s_in,
    output logic [8:0]    s_out,
    output logic          s_oe
);

    logic [AW-1:0] addr_q;
    op_e           op;
    logic          p_is_src;
    logic          s_is_src;
    logic          wr_en;
    word_t         wdata;
    word_t         rdata;

    dbsram_ctrl #(.AW(AW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .addr      (addr),
        .chip_en_n (chip_en_n),
        .chip_en   (chip_en),
        .wr_n      (wr_n),
        .p_in_en_n (p_in_en_n),
        .s_in_en_n (s_in_en_n),
        .addr_q    (addr_q),
        .op        (op),
        .p_is_src  (p_is_src),
        .s_is_src  (s_is_src)
    );

    assign wr_en = (op == OP_WR_P) || (op == OP_WR_S);
    assign wdata = (op == OP_WR_S) ? s_in : p_in;

    dbsram_array #(.AW(AW)) u_array (
        .clk   (clk),
        .addr  (addr_q),
        .wr_en (wr_en),
        .wdata (wdata),
        .rdata (rdata)
    );

    dbsram_busio u_busio (
        .clk        (clk),
        .rst        (rst),
        .op         (op),
        .p_is_src   (p_is_src),
        .s_is_src   (s_is_src),
        .p_in       (p_in),
        .s_in       (s_in),
        .rdata      (rdata),
        .p_out_en_n (p_out_en_n),
        .s_out_en_n (s_out_en_n),
        .p_out      (p_out),
        .s_out      (s_out),
        .p_oe       (p_oe),
        .s_oe       (s_oe)
    );

endmodule

// File: tb/test_dual_bus_sram.sv
module test_dual_bus_sram;

    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          wr_n = 1'b1, chip_en_n = 1'b1, chip_en = 1'b0;
    logic          p_in_en_n = 1'b1, s_in_en_n = 1'b1;
    logic          p_out_en_n = 1'b0, s_out_en_n = 1'b0;
    logic [8:0]    p_in = '0, s_in = '0;
    logic [8:0]    p_out, s_out;
    logic          p_oe, s_oe;

    logic [8:0]    ref_mem [DEPTH];
    int            n_chk = 0;
    int            n_fail = 0;

    always #4 clk = ~clk;

    dual_bus_sram #(.AW(AW)) i_dual_bus_sram (
        .clk(clk), .rst(rst), .addr(addr), .wr_n(wr_n),
        .chip_en_n(chip_en_n), .chip_en(chip_en),
        .p_in_en_n(p_in_en_n), .s_in_en_n(s_in_en_n),
        .p_out_en_n(p_out_en_n), .s_out_en_n(s_out_en_n),
        .p_in(p_in), .p_out(p_out), .p_oe(p_oe),
        .s_in(s_in), .s_out(s_out), .s_oe(s_oe)
    );

    function automatic logic [8:0] pat(input int a, input int k);
        return 9'((a * 37 + k * 101 + 5) % 512);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one cycle's inputs just after a rising edge, then run to the next rising edge
    task automatic cyc(input int a, input logic w, input logic c1n, input logic c2,
                       input logic pe, input logic se, input logic po, input logic so,
                       input logic [8:0] pd, input logic [8:0] sd);
        addr = AW'(a); wr_n = w; chip_en_n = c1n; chip_en = c2;
        p_in_en_n = pe; s_in_en_n = se; p_out_en_n = po; s_out_en_n = so;
        p_in = pd; s_in = sd;
        @(posedge clk); #1;
    endtask

    task automatic rd(input int a);
        cyc(a, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0, '0);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R12 reset p_oe", 32'(p_oe), 0);
        chk("R12 reset s_oe", 32'(s_oe), 0);
        rst = 1'b0;
        @(posedge clk); #1;
        chk("R12 after reset p_oe", 32'(p_oe), 0);
        chk("R12 after reset s_oe", 32'(s_oe), 0);

        // R2 R4 R5: fill every address, even from P, odd from S, streaming out the other bus
        for (int a = 0; a < DEPTH; a++) begin
            ref_mem[a] = pat(a, 0);
            if (a % 2 == 0) begin
                cyc(a, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, ref_mem[a], ~ref_mem[a]);
                chk("R5 stream P->S s_oe", 32'(s_oe), 1);
                chk("R5 stream P->S s_out", 32'(s_out), 32'(ref_mem[a]));
                chk("R5 source P quiet", 32'(p_oe), 0);
            end else begin
                cyc(a, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, ~ref_mem[a], ref_mem[a]);
                chk("R5 stream S->P p_oe", 32'(p_oe), 1);
                chk("R5 stream S->P p_out", 32'(p_out), 32'(ref_mem[a]));
                chk("R5 source S quiet", 32'(s_oe), 0);
            end
        end

        // R9 R2 R4: read back every word on both buses
        for (int a = 0; a < DEPTH; a++) begin
            rd(a);
            chk("R9 read p_out", 32'(p_out), 32'(ref_mem[a]));
            chk("R9 read s_out", 32'(s_out), 32'(ref_mem[a]));
            chk("R9 read drive", 32'({p_oe, s_oe}), 3);
        end

        // R8: after a read both buses drive; a P-sourced write cycle must silence P before the edge
        rd(3);
        addr = AW'(3); wr_n = 1'b0; p_in_en_n = 1'b0; s_in_en_n = 1'b1;
        p_in = pat(3, 1); #1;
        chk("R8 P source quiet before edge", 32'(p_oe), 0);
        chk("R8 S still drives", 32'(s_oe), 1);
        @(posedge clk); #1;
        ref_mem[3] = pat(3, 1);
        rd(5);
        addr = AW'(5); wr_n = 1'b0; p_in_en_n = 1'b1; s_in_en_n = 1'b0;
        s_in = pat(5, 1); #1;
        chk("R8 S source quiet before edge", 32'(s_oe), 0);
        @(posedge clk); #1;
        ref_mem[5] = pat(5, 1);

        // R7: output-enable release without an edge
        rd(7);
        p_out_en_n = 1'b1; #1;
        chk("R7 p release", 32'(p_oe), 0);
        chk("R7 s unaffected", 32'(s_oe), 1);
        s_out_en_n = 1'b1; #1;
        chk("R7 s release", 32'(s_oe), 0);
        @(posedge clk); #1;

        // R3 R6: equal input-enable pairs are no-operations
        for (int a = 10; a < 20; a++) begin
            rd(a);
            cyc(a, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, pat(a, 2), pat(a, 3));
            chk("R6 both high quiet", 32'({p_oe, s_oe}), 0);
            cyc(a, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, pat(a, 2), pat(a, 3));
            chk("R6 both low quiet", 32'({p_oe, s_oe}), 0);
            rd(a);
            chk("R3 nop keeps word", 32'(p_out), 32'(ref_mem[a]));
        end

        // R1 R10: inactive chip-select combinations reject the write
        for (int c = 0; c < 3; c++) begin
            logic c1n, c2;
            c1n = (c != 1);
            c2  = (c == 1) ? 1'b0 : (c == 2);
            cyc(20 + c, 1'b0, c1n, c2, 1'b0, 1'b1, 1'b0, 1'b0, pat(20 + c, 4), '0);
            chk("R10 deselect quiet", 32'({p_oe, s_oe}), 0);
            cyc(20 + c, 1'b1, c1n, c2, 1'b1, 1'b1, 1'b0, 1'b0, '0, '0);
            chk("R10 deselect read quiet", 32'({p_oe, s_oe}), 0);
            rd(20 + c);
            chk("R1 rejected write", 32'(s_out), 32'(ref_mem[20 + c]));
        end

        // R11: changes after the falling edge are ignored
        addr = AW'(30); wr_n = 1'b0; chip_en_n = 1'b0; chip_en = 1'b1;
        p_in_en_n = 1'b0; s_in_en_n = 1'b1; p_in = pat(30, 5);
        @(negedge clk); #1;
        addr = AW'(31); chip_en_n = 1'b1; chip_en = 1'b0;
        @(posedge clk); #1;
        ref_mem[30] = pat(30, 5);
        chk("R11 late deselect ignored", 32'(s_oe), 1);
        rd(30);
        chk("R11 captured address written", 32'(p_out), 32'(ref_mem[30]));
        rd(31);
        chk("R11 late address untouched", 32'(p_out), 32'(ref_mem[31]));

        // final sweep of the whole array
        for (int a = 0; a < DEPTH; a++) begin
            rd(a);
            chk("R4 final contents", 32'(s_out), 32'(ref_mem[a]));
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule